// File: doc/BRIEF.md
# Instrument Supervisory Controller

This block sequences an acquisition instrument through its life cycle: device start-up, an idle state that waits for host commands, three kinds of work (generic command handling, self-calibration and measurement acquisition) and a fault-holding state. It issues a one-cycle start pulse to the sub-operation it enters. It then waits for that sub-operation's done or fault handshake. It also watches two global fault inputs, one carrying hardware status and one carrying a processor error code.

The host sees one status word. Its low field names the current state. Its high field carries an error code. On a fault, the state field is deliberately not updated, so it keeps naming the state that failed. One cycle later the error field is filled with a code built from that state, a hardware-fault flag and the processor's error code. The host leaves the fault state with a restart command, which re-runs start-up, or a resume command, which returns to idle. Commands that arrive when the controller cannot take them are dropped and counted.

Top module: `isup_supervisor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the state is start-up, `status` is 0, `rej_count` is 0, `cfg_cmd` is 0 and `boot_start` is 1 with the other start pulses low.
- R2: In start-up, `boot_ok` moves the controller to idle in the next cycle.
- R3: In idle, an accepted command with code 0x1 enters calibration and pulses `cal_start`. Code 0x2 enters acquisition and pulses `acq_start`. Any other code enters command handling, pulses `cfg_start` and loads the code into `cfg_cmd`.
- R4: In command handling, calibration or acquisition, that sub-operation's ok input returns the controller to idle in the next cycle.
- R5: In any state except fault, a fault moves the controller to the fault state in the next cycle. A fault is the current sub-operation's error input, a nonzero `fpga_stat` or a nonzero `proc_err`. A fault takes priority over an ok input or a command in the same cycle.
- R6: `status[2:0]` holds the state code (start-up 0, idle 1, command 2, calibration 3, acquisition 4, fault 5). It changes on every state change except entry into the fault state, where it keeps the failing state's code. `status[10:3]` is 0 outside the fault state.
- R7: From the second cycle in the fault state onward, `status[10:3]` holds the error code. Its bits [7:5] are the failing state's code, bit 4 is 1 when `fpga_stat` was nonzero, and bits [3:0] are `proc_err`. All three are sampled in the cycle the fault was seen.
- R8: In the fault state, code 0xE moves the controller to start-up with a `boot_start` pulse, and code 0xF moves it to idle. Any other command leaves the state and `status` unchanged.
- R9: A command that is not accepted leaves the state unchanged and increments `rej_count`, which saturates at 255. Commands are accepted in idle without a fault, and 0xE/0xF are accepted in the fault state.
- R10: Start pulses last one cycle, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| boot_ok | input | 1 | Start-up finished |
| boot_err | input | 1 | Start-up failed |
| cfg_ok | input | 1 | Command handling finished |
| cfg_err | input | 1 | Command handling failed |
| cal_ok | input | 1 | Self-calibration finished |
| cal_err | input | 1 | Self-calibration failed |
| acq_ok | input | 1 | Acquisition finished |
| acq_err | input | 1 | Acquisition failed |
| fpga_stat | input | 4 | Hardware status, nonzero means fault |
| proc_err | input | 4 | Processor error code, nonzero means fault |
| boot_start | output | 1 | Start pulse for start-up |
| cfg_start | output | 1 | Start pulse for command handling |
| cal_start | output | 1 | Start pulse for self-calibration |
| acq_start | output | 1 | Start pulse for acquisition |
| cfg_cmd | output | 4 | Code of the last command sent to command handling |
| status | output | 11 | {error code, state code} |
| rej_count | output | 8 | Saturating count of rejected commands |

## Verification
Every output is a register, so a wrong next-state decision shows up at `status[2:0]` or a start pulse one cycle after the offending input. The bench compares every cycle against a model built from the requirements. A mistake in freezing the state field on fault entry appears in that same cycle. A wrong or mistimed error snapshot appears one cycle later in `status[10:3]`. A bad accept/reject decision shows in `rej_count` on the next edge, even when the state itself stays put.

// File: rtl/isup_pkg.sv
package isup_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    S_BOOT  = 3'd0,
    S_READY = 3'd1,
    S_CMD   = 3'd2,
    S_CAL   = 3'd3,
    S_ACQ   = 3'd4,
    S_RECOV = 3'd5
  } sup_state_e;

  typedef enum logic [2:0] {
    K_CAL,
    K_MEAS,
    K_RESTART,
    K_RESUME,
    K_OTHER
  } cmd_kind_e;
endpackage

// File: rtl/isup_cmd_decode.sv
module isup_cmd_decode #(
  parameter int              CMD_W        = 4,
  parameter logic [CMD_W-1:0] CODE_CAL     = 4'h1,
  parameter logic [CMD_W-1:0] CODE_MEAS    = 4'h2,
  parameter logic [CMD_W-1:0] CODE_RESTART = 4'hE,
  parameter logic [CMD_W-1:0] CODE_RESUME  = 4'hF
) (
  input  logic [CMD_W-1:0]   code,
  output isup_pkg::cmd_kind_e kind
);
  import isup_pkg::*;

  always_comb begin
    if (code == CODE_CAL)          kind = K_CAL;
    else if (code == CODE_MEAS)    kind = K_MEAS;
    else if (code == CODE_RESTART) kind = K_RESTART;
    else if (code == CODE_RESUME)  kind = K_RESUME;
    else                           kind = K_OTHER;
  end
endmodule

// File: rtl/isup_fault_detect.sv
module isup_fault_detect #(
  parameter int FST_W  = 4,
  parameter int PERR_W = 4
) (
  input  isup_pkg::sup_state_e state,
  input  logic                 boot_err,
  input  logic                 cfg_err,
  input  logic                 cal_err,
  input  logic                 acq_err,
  input  logic [FST_W-1:0]     fpga_stat,
  input  logic [PERR_W-1:0]    proc_err,
  output logic                 fpga_flag,
  output logic                 fault
);
  import isup_pkg::*;

  logic sub_err;

  // Only the sub-operation that is running may raise its own error
  always_comb begin
    case (state)
      S_BOOT:  sub_err = boot_err;
      S_CMD:   sub_err = cfg_err;
      S_CAL:   sub_err = cal_err;
      S_ACQ:   sub_err = acq_err;
      default: sub_err = 1'b0;
    endcase
  end

  assign fpga_flag = |fpga_stat;
  assign fault     = (state != S_RECOV) && (sub_err || fpga_flag || (|proc_err));
endmodule

// File: rtl/isup_err_latch.sv
module isup_err_latch #(
  parameter  int PERR_W = 4,
  localparam int ERR_W  = isup_pkg::ST_W + 1 + PERR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  isup_pkg::sup_state_e at_state,
  input  logic                 fpga_flag,
  input  logic [PERR_W-1:0]    proc_err,
  output logic [ERR_W-1:0]     code
);
  // Snapshot of the fault context, taken in the cycle the fault is seen
  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (capture) code <= {at_state, fpga_flag, proc_err};
  end

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(code));
endmodule

// File: rtl/isup_rej_counter.sv
module isup_rej_counter #(
  parameter int RC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  output logic [RC_W-1:0] count
);
  localparam logic [RC_W-1:0] CNT_MAX = {RC_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                         count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  // R9
  rej_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count >= $past(count));
  // R9
  rej_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/isup_supervisor.sv
module isup_supervisor #(
  parameter  int               CMD_W        = 4,
  parameter  int               FST_W        = 4,
  parameter  int               PERR_W       = 4,
  parameter  int               RC_W         = 8,
  parameter  logic [CMD_W-1:0] CODE_CAL     = 4'h1,
  parameter  logic [CMD_W-1:0] CODE_MEAS    = 4'h2,
  parameter  logic [CMD_W-1:0] CODE_RESTART = 4'hE,
  parameter  logic [CMD_W-1:0] CODE_RESUME  = 4'hF,
  localparam int               ERR_W        = isup_pkg::ST_W + 1 + PERR_W,
  localparam int               STAT_W       = isup_pkg::ST_W + ERR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              boot_ok,
  input  logic              boot_err,
  input  logic              cfg_ok,
  input  logic              cfg_err,
  input  logic              cal_ok,
  input  logic              cal_err,
  input  logic              acq_ok,
  input  logic              acq_err,
  input  logic [FST_W-1:0]  fpga_stat,
  input  logic [PERR_W-1:0] proc_err,
  output logic              boot_start,
  output logic              cfg_start,
  output logic              cal_start,
  output logic              acq_start,
  output logic [CMD_W-1:0]  cfg_cmd,
  output logic [STAT_W-1:0] status,
  output logic [RC_W-1:0]   rej_count
);
  import isup_pkg::*;

  sup_state_e       state_q, state_d;
  cmd_kind_e        kind;
  logic             fault, fpga_flag, accept;
  logic [ERR_W-1:0] err_code;

  isup_cmd_decode #(
    .CMD_W(CMD_W), .CODE_CAL(CODE_CAL), .CODE_MEAS(CODE_MEAS),
    .CODE_RESTART(CODE_RESTART), .CODE_RESUME(CODE_RESUME)
  ) u_decode (
    .code (cmd_code),
    .kind (kind)
  );

  isup_fault_detect #(.FST_W(FST_W), .PERR_W(PERR_W)) u_fault (
    .state     (state_q),
    .boot_err  (boot_err),
    .cfg_err   (cfg_err),
    .cal_err   (cal_err),
    .acq_err   (acq_err),
    .fpga_stat (fpga_stat),
    .proc_err  (proc_err),
    .fpga_flag (fpga_flag),
    .fault     (fault)
  );

  isup_err_latch #(.PERR_W(PERR_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .capture   (fault),
    .at_state  (state_q),
    .fpga_flag (fpga_flag),
    .proc_err  (proc_err),
    .code      (err_code)
  );

  isup_rej_counter #(.RC_W(RC_W)) u_rej (
    .clk   (clk),
    .rst   (rst),
    .inc   (cmd_valid && !accept),
    .count (rej_count)
  );

  // Next-state selection: a fault outranks everything else
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    if (fault) begin
      state_d = S_RECOV;
    end else begin
      case (state_q)
        S_BOOT:  if (boot_ok) state_d = S_READY;
        S_READY: if (cmd_valid) begin
          accept = 1'b1;
          case (kind)
            K_CAL:   state_d = S_CAL;
            K_MEAS:  state_d = S_ACQ;
            default: state_d = S_CMD;
          endcase
        end
        S_CMD:   if (cfg_ok) state_d = S_READY;
        S_CAL:   if (cal_ok) state_d = S_READY;
        S_ACQ:   if (acq_ok) state_d = S_READY;
        S_RECOV: if (cmd_valid) begin
          if (kind == K_RESTART) begin
            accept  = 1'b1;
            state_d = S_BOOT;
          end else if (kind == K_RESUME) begin
            accept  = 1'b1;
            state_d = S_READY;
          end
        end
        default: state_d = S_BOOT;
      endcase
    end
  end

  wire changing = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_BOOT;
      boot_start <= 1'b1;
      cfg_start  <= 1'b0;
      cal_start  <= 1'b0;
      acq_start  <= 1'b0;
      cfg_cmd    <= '0;
      status     <= {{ERR_W{1'b0}}, S_BOOT};
    end else begin
      state_q    <= state_d;
      boot_start <= changing && (state_d == S_BOOT);
      cfg_start  <= changing && (state_d == S_CMD);
      cal_start  <= changing && (state_d == S_CAL);
      acq_start  <= changing && (state_d == S_ACQ);
      if (accept && state_d == S_CMD) cfg_cmd <= cmd_code;
      // The state field is left alone on entry to the fault state
      if (changing && state_d != S_RECOV)
        status <= {{ERR_W{1'b0}}, state_d};
      else if (state_q == S_RECOV)
        status[STAT_W-1:ST_W] <= err_code;
    end
  end

  // R10
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({boot_start, cfg_start, cal_start, acq_start}));
  // R6
  recov_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RECOV && $past(state_q) != S_RECOV) |-> status[ST_W-1:0] == $past(status[ST_W-1:0]));
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_RECOV) |-> status[STAT_W-1:ST_W] == '0);
  // R8
  recov_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == S_RECOV && state_q != S_RECOV) |-> (state_q == S_BOOT || state_q == S_READY));
  // R3
  cal_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> $past(state_q) == S_READY);
  // R5
  fault_to_recov_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> state_q == S_RECOV);
endmodule

// File: tb/isup_supervisor_test.sv
module isup_supervisor_test;
  localparam logic [2:0] M_BOOT = 3'd0, M_RDY = 3'd1, M_CMD = 3'd2,
                         M_CAL = 3'd3, M_ACQ = 3'd4, M_REC = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0; logic [3:0] cmd_code = 0;
  logic boot_ok = 0, boot_err = 0, cfg_ok = 0, cfg_err = 0;
  logic cal_ok = 0, cal_err = 0, acq_ok = 0, acq_err = 0;
  logic [3:0] fpga_stat = 0, proc_err = 0;
  logic boot_start, cfg_start, cal_start, acq_start;
  logic [3:0] cfg_cmd; logic [10:0] status; logic [7:0] rej_count;

  isup_supervisor uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .boot_ok(boot_ok), .boot_err(boot_err), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
    .cal_ok(cal_ok), .cal_err(cal_err), .acq_ok(acq_ok), .acq_err(acq_err),
    .fpga_stat(fpga_stat), .proc_err(proc_err),
    .boot_start(boot_start), .cfg_start(cfg_start), .cal_start(cal_start),
    .acq_start(acq_start), .cfg_cmd(cfg_cmd), .status(status), .rej_count(rej_count)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic done = 0;

  // expected-value model state
  logic [2:0]  m_st; logic [10:0] m_stat; logic [7:0] m_code, m_rej;
  logic [3:0]  m_starts, m_cfg;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic model_reset();
    m_st = M_BOOT; m_stat = '0; m_code = '0; m_rej = '0; m_starts = 4'b1000; m_cfg = '0;
  endtask

  // Next-cycle expectation from the requirements (R2..R10)
  task automatic model_step();
    logic [2:0] n; logic acc, serr, flt;
    n = m_st; acc = 0;
    case (m_st)
      M_BOOT: serr = boot_err; M_CMD: serr = cfg_err;
      M_CAL:  serr = cal_err;  M_ACQ: serr = acq_err;
      default: serr = 0;
    endcase
    flt = (m_st != M_REC) && (serr || fpga_stat != 0 || proc_err != 0);
    if (flt) begin
      n = M_REC; m_code = {m_st, fpga_stat != 0, proc_err};
    end else begin
      case (m_st)
        M_BOOT: if (boot_ok) n = M_RDY;
        M_RDY: if (cmd_valid) begin
          acc = 1;
          n = (cmd_code == 4'h1) ? M_CAL : (cmd_code == 4'h2) ? M_ACQ : M_CMD;
          if (n == M_CMD) m_cfg = cmd_code;
        end
        M_CMD: if (cfg_ok) n = M_RDY;
        M_CAL: if (cal_ok) n = M_RDY;
        M_ACQ: if (acq_ok) n = M_RDY;
        default: if (cmd_valid && cmd_code == 4'hE) begin acc = 1; n = M_BOOT; end
                 else if (cmd_valid && cmd_code == 4'hF) begin acc = 1; n = M_RDY; end
      endcase
    end
    if (cmd_valid && !acc && m_rej != 8'hFF) m_rej = m_rej + 1;
    m_starts = 4'b0;
    if (n != m_st) begin
      case (n)
        M_BOOT: m_starts = 4'b1000; M_CMD: m_starts = 4'b0100;
        M_CAL:  m_starts = 4'b0010; M_ACQ: m_starts = 4'b0001;
        default: m_starts = 4'b0;
      endcase
    end
    if (n != m_st && n != M_REC) m_stat = {8'h0, n};
    else if (m_st == M_REC) m_stat[10:3] = m_code;
    m_st = n;
  endtask

  task automatic compare();
    check("R6 R7 status", status, m_stat);
    check("R10 start pulses", {boot_start, cfg_start, cal_start, acq_start}, m_starts);
    check("R3 cfg_cmd", cfg_cmd, m_cfg);
    check("R9 rej_count", rej_count, m_rej);
  endtask

  task automatic clear_in();
    cmd_valid = 0; cmd_code = 0; boot_ok = 0; boot_err = 0; cfg_ok = 0; cfg_err = 0;
    cal_ok = 0; cal_err = 0; acq_ok = 0; acq_err = 0; fpga_stat = 0; proc_err = 0;
  endtask

  // inputs are set before this call at a negedge; advance one edge and compare
  task automatic tick();
    model_step();
    @(posedge clk); #1;
    compare();
    @(negedge clk);
    clear_in();
  endtask

  task automatic cmd(logic [3:0] c);
    cmd_valid = 1; cmd_code = c; tick();
  endtask

  task automatic do_reset();
    rst = 1; clear_in();
    repeat (2) @(posedge clk);
    #1; model_reset();
    // R1: reset values
    check("R1 status", status, 11'h0);
    check("R1 boot_start", {boot_start, cfg_start, cal_start, acq_start}, 4'b1000);
    check("R1 rej_count", rej_count, 8'h0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    #1;
    // R1: first cycle after reset still shows start-up
    check("R1 state", status, 11'h0);
    boot_ok = 1; tick();                                 // R2
    check("R2 to idle", status[2:0], M_RDY);
    cmd(4'h1);                                           // R3 calibration
    check("R3 cal_start", cal_start, 1'b1);
    cal_ok = 1; tick();                                  // R4
    check("R4 back to idle", status[2:0], M_RDY);
    cmd(4'h2);                                           // R3 acquisition
    acq_ok = 1; proc_err = 4'h9; tick();                 // R5 fault beats ok
    check("R6 frozen state field", status, {8'h0, M_ACQ});
    tick();
    check("R7 error code", status[10:3], {M_ACQ, 1'b0, 4'h9});
    cmd(4'h1);                                           // R8 ignored in fault
    check("R8 stays in fault", status, {M_ACQ, 1'b0, 4'h9, M_ACQ});
    check("R9 rejected", rej_count, 8'd1);
    cmd(4'hF);                                           // R8 resume
    check("R8 resume", status, {8'h0, M_RDY});
    cmd(4'h7);                                           // R3 other code
    check("R3 cfg_cmd", cfg_cmd, 4'h7);
    cmd(4'h2);                                           // R9 busy reject
    check("R9 busy", status[2:0], M_CMD);
    cfg_err = 1; fpga_stat = 4'h4; tick();               // R5
    tick();
    check("R7 fpga flag", status[10:3], {M_CMD, 1'b1, 4'h0});
    cmd(4'hE);                                           // R8 restart
    check("R8 restart", boot_start, 1'b1);
    for (int i = 0; i < 300; i++) cmd(4'h3);             // R9 saturation in start-up
    check("R9 saturate", rej_count, 8'hFF);

    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      if ($urandom % 10 < 3) begin
        r = $urandom % 6;
        cmd_valid = 1;
        cmd_code = (r == 0) ? 4'h1 : (r == 1) ? 4'h2 : (r == 2) ? 4'hE :
                   (r == 3) ? 4'hF : 4'($urandom % 16);
      end
      boot_ok = ($urandom % 5 == 0); cfg_ok = ($urandom % 5 == 0);
      cal_ok  = ($urandom % 5 == 0); acq_ok = ($urandom % 5 == 0);
      boot_err = ($urandom % 40 == 0); cfg_err = ($urandom % 40 == 0);
      cal_err  = ($urandom % 40 == 0); acq_err = ($urandom % 40 == 0);
      if ($urandom % 60 == 0) fpga_stat = 4'($urandom % 16);
      if ($urandom % 60 == 0) proc_err  = 4'($urandom % 16);
      tick();
    end
    done = 1;
    summary();
  end
endmodule